// File: doc/BRIEF.md
# Dual-Port Memory with Address Contention Arbitration

This block is a synchronous two-port memory, a left port and a right port, wrapped in logic that notices when both ports select the same word in the same cycle. When they do, one port keeps its access and the other is told to back off through an active-low busy flag. The port that backs off has its write dropped, so a shared word is never written by both sides at once. Reads are never blocked. A port that reads a word on the same edge the other port writes it gets the old contents, and sees the new contents on its next read.

A mode strap selects the role. As a master, the block runs the arbitration itself and drives the busy flags out. As a slave, it does not arbitrate. It takes busy flags in from a master and uses them to drop its own writes. Several devices can then share one master's decision and act as one wider memory.

Top module: `dpram_arb`

## Requirements
- R1: An enabled read (`*_cs_n` low, `*_we_n` high at a rising edge) puts the addressed word on that port's `*_rdata` one cycle later. An enabled write stores `*_wdata` at the address. `*_rdata` keeps its value in every cycle that port does not read.
- R2: Contention exists only when both `*_cs_n` are low and `l_addr` equals `r_addr` at the same edge. In any other case neither busy flag goes low.
- R3: When a port was already enabled on the matching address in the previous cycle and the other port was not, the first port wins. In master mode, the other port's `*_busy_out_n` is low in the cycle after the edge where the match is seen.
- R4: When both ports arrive on the matching address at the same edge, the left port wins and `r_busy_out_n` goes low.
- R5: In master mode, the write of the losing port is dropped at every edge where it loses. The winner's write is stored.
- R6: A busy flag returns high in the cycle after the match ends, whether the addresses have diverged or a chip enable has gone high.
- R7: A read at the same edge as a write by the other port to the same word returns the previous contents. The next read returns the new word.
- R8: In slave mode (`master_sel` low), both `*_busy_out_n` are held high. A low `*_busy_in_n` at an edge drops that port's write, and reads still take place.
- R9: After reset both busy outputs are high and both read data outputs are zero.
- R10: Once a winner is chosen, it keeps ownership for as long as the match continues, even after both ports have been present for more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_sel | input | 1 | 1: master (arbitrate, drive busy), 0: slave (take busy in) |
| l_cs_n | input | 1 | Left chip enable, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_addr | input | AW | Left word address |
| l_wdata | input | DW | Left write data |
| l_busy_in_n | input | 1 | Left busy from a master, used in slave mode |
| l_rdata | output | DW | Left read data, registered |
| l_busy_out_n | output | 1 | Left busy flag, active low |
| r_cs_n | input | 1 | Right chip enable, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_addr | input | AW | Right word address |
| r_wdata | input | DW | Right write data |
| r_busy_in_n | input | 1 | Right busy from a master, used in slave mode |
| r_rdata | output | DW | Right read data, registered |
| r_busy_out_n | output | 1 | Right busy flag, active low |

## Verification
The bench targets ties on the same edge, where a design that favours the wrong side or lets both sides win would store the right port's data or flag both ports. It drives late arrivals against a port that is already holding the word, which catches a design that ignores arrival order or that hands ownership over once both sides have been present. It places same-edge reads against writes to check that the read returns the old word rather than passing the new data straight through. It also ends matches through address divergence and through a dropped chip enable, where a busy flag that stays low would show up. In slave mode it checks that a design still arbitrating on its own would pull a busy output low, and that a design ignoring the busy input would store a blocked write.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // Both ports enabled on one word.
  function automatic logic word_clash(input logic l_en, input logic r_en,
                                      input logic [31:0] l_a, input logic [31:0] r_a);
    return l_en && r_en && (l_a == r_a);
  endfunction

  // Fresh contest: whoever was already parked on the word wins; ties go left.
  function automatic owner_e pick_first(input logic l_held, input logic r_held);
    if (r_held && !l_held) return OWN_RIGHT;
    return OWN_LEFT;
  endfunction

endpackage

// File: rtl/dpa_arbiter.sv
module dpa_arbiter
  import dpa_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_sel,
  input  logic          l_en,
  input  logic          r_en,
  input  logic [AW-1:0] l_addr,
  input  logic [AW-1:0] r_addr,
  output logic          clash,
  output logic          l_lose,
  output logic          r_lose,
  output logic          l_busy_q,
  output logic          r_busy_q
);

  logic          l_en_q, r_en_q;
  logic [AW-1:0] l_addr_q, r_addr_q;
  owner_e        owner_q, winner;
  logic          l_held, r_held;

  always_comb begin
    clash  = word_clash(l_en, r_en, 32'(l_addr), 32'(r_addr));
    l_held = l_en_q && (l_addr_q == l_addr);
    r_held = r_en_q && (r_addr_q == r_addr);
    if (!clash)                 winner = OWN_NONE;
    else if (owner_q != OWN_NONE) winner = owner_q;
    else                        winner = pick_first(l_held, r_held);
    l_lose = (winner == OWN_RIGHT);
    r_lose = (winner == OWN_LEFT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_en_q   <= 1'b0;
      r_en_q   <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
      owner_q  <= OWN_NONE;
      l_busy_q <= 1'b0;
      r_busy_q <= 1'b0;
    end else begin
      l_en_q   <= l_en;
      r_en_q   <= r_en;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
      owner_q  <= winner;
      l_busy_q <= master_sel && l_lose;
      r_busy_q <= master_sel && r_lose;
    end
  end

  // R3
  busy_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_busy_q && r_busy_q));

  // R6
  l_busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_busy_q |-> $past(clash));

  // R6
  r_busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_busy_q |-> $past(clash));

  // R2
  no_clash_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clash |=> !(l_busy_q || r_busy_q));

endmodule

// File: rtl/dpa_port_gate.sv
module dpa_port_gate (
  input  logic master_sel,
  input  logic cs_n,
  input  logic we_n,
  input  logic lose,
  input  logic busy_in_n,
  input  logic busy_q,
  output logic en,
  output logic rd,
  output logic wr,
  output logic busy_out_n
);

  logic blocked;

  always_comb begin
    en         = !cs_n;
    blocked    = master_sel ? lose : !busy_in_n;
    rd         = en && we_n;
    wr         = en && !we_n && !blocked;
    busy_out_n = master_sel ? !busy_q : 1'b1;
  end

endmodule

// File: rtl/dpa_array.sv
module dpa_array #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_rd,
  input  logic          l_wr,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic          r_rd,
  input  logic          r_wr,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (l_wr) store[l_addr] <= l_wdata;
    if (r_wr) store[r_addr] <= r_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rdata <= '0;
      r_rdata <= '0;
    end else begin
      if (l_rd) l_rdata <= store[l_addr];
      if (r_rd) r_rdata <= store[r_addr];
    end
  end

  // R1
  l_rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !l_rd |=> $stable(l_rdata));

  // R1
  r_rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !r_rd |=> $stable(r_rdata));

endmodule

// File: rtl/dpram_arb.sv
module dpram_arb #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_sel,
  input  logic          l_cs_n,
  input  logic          l_we_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  input  logic          l_busy_in_n,
  output logic [DW-1:0] l_rdata,
  output logic          l_busy_out_n,
  input  logic          r_cs_n,
  input  logic          r_we_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  input  logic          r_busy_in_n,
  output logic [DW-1:0] r_rdata,
  output logic          r_busy_out_n
);

  logic l_en, r_en, l_rd, r_rd, l_wr, r_wr;
  logic clash, l_lose, r_lose, l_busy_q, r_busy_q;

  dpa_port_gate u_lgate (
    .master_sel(master_sel), .cs_n(l_cs_n), .we_n(l_we_n), .lose(l_lose),
    .busy_in_n(l_busy_in_n), .busy_q(l_busy_q),
    .en(l_en), .rd(l_rd), .wr(l_wr), .busy_out_n(l_busy_out_n)
  );

  dpa_port_gate u_rgate (
    .master_sel(master_sel), .cs_n(r_cs_n), .we_n(r_we_n), .lose(r_lose),
    .busy_in_n(r_busy_in_n), .busy_q(r_busy_q),
    .en(r_en), .rd(r_rd), .wr(r_wr), .busy_out_n(r_busy_out_n)
  );

  dpa_arbiter #(.AW(AW)) u_arb (
    .clk(clk), .rst_n(rst_n), .master_sel(master_sel),
    .l_en(l_en), .r_en(r_en), .l_addr(l_addr), .r_addr(r_addr),
    .clash(clash), .l_lose(l_lose), .r_lose(r_lose),
    .l_busy_q(l_busy_q), .r_busy_q(r_busy_q)
  );

  dpa_array #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .l_rd(l_rd), .l_wr(l_wr), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_rd(r_rd), .r_wr(r_wr), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  // R5
  l_loser_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && l_busy_q && clash) |-> !l_wr);

  // R5
  r_loser_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && r_busy_q && clash) |-> !r_wr);

  // R5
  never_double_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && clash) |-> !(l_wr && r_wr));

  // R8
  slave_busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_sel |-> (l_busy_out_n && r_busy_out_n));

  // R8
  slave_l_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_sel && !l_busy_in_n) |-> !l_wr);

endmodule

// File: tb/dpram_arb_test.sv
module dpram_arb_test;

  localparam int AW = 6;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b1;
  logic l_cs_n = 1'b1, l_we_n = 1'b1, l_bi = 1'b1;
  logic r_cs_n = 1'b1, r_we_n = 1'b1, r_bi = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_bo, r_bo;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dpram_arb #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .master_sel(mode),
    .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_busy_in_n(l_bi), .l_rdata(l_rdata), .l_busy_out_n(l_bo),
    .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_busy_in_n(r_bi), .r_rdata(r_rdata), .r_busy_out_n(r_bo)
  );

  // reference model state
  logic [DW-1:0] mm [DEPTH];
  logic [DW-1:0] m_rd_l = '0, m_rd_r = '0;
  int            m_own = 0;
  logic          m_pen_l = 0, m_pen_r = 0, m_busy_l = 0, m_busy_r = 0;
  logic [AW-1:0] m_pal = '0, m_par = '0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int pick(input logic lh, input logic rh);
    return (rh && !lh) ? 2 : 1;
  endfunction

  task automatic model_edge();
    logic match, lh, rh, lose_l, lose_r, wl, wr;
    int win;
    match = !l_cs_n && !r_cs_n && (l_addr == r_addr);
    lh = m_pen_l && (m_pal == l_addr);
    rh = m_pen_r && (m_par == r_addr);
    win = !match ? 0 : (m_own != 0 ? m_own : pick(lh, rh));
    lose_l = (win == 2);
    lose_r = (win == 1);
    wl = !l_cs_n && !l_we_n && !(mode ? lose_l : !l_bi);
    wr = !r_cs_n && !r_we_n && !(mode ? lose_r : !r_bi);
    if (!l_cs_n && l_we_n) m_rd_l = mm[l_addr];
    if (!r_cs_n && r_we_n) m_rd_r = mm[r_addr];
    if (wl) mm[l_addr] = l_wdata;
    if (wr) mm[r_addr] = r_wdata;
    m_own = win;
    m_pen_l = !l_cs_n; m_pal = l_addr;
    m_pen_r = !r_cs_n; m_par = r_addr;
    m_busy_l = mode && lose_l;
    m_busy_r = mode && lose_r;
  endtask

  task automatic step(input logic lcs, input logic lwe, input int la, input int ld,
                      input logic rcs, input logic rwe, input int ra, input int rd,
                      input logic lbi, input logic rbi, input string tag);
    l_cs_n = lcs; l_we_n = lwe; l_addr = AW'(la); l_wdata = DW'(ld);
    r_cs_n = rcs; r_we_n = rwe; r_addr = AW'(ra); r_wdata = DW'(rd);
    l_bi = lbi; r_bi = rbi;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, "l_rdata", int'(l_rdata), int'(m_rd_l));
    check(tag, "r_rdata", int'(r_rdata), int'(m_rd_r));
    check(tag, "l_busy_out_n", int'(l_bo), mode ? int'(!m_busy_l) : 1);
    check(tag, "r_busy_out_n", int'(r_bo), mode ? int'(!m_busy_r) : 1);
  endtask

  task automatic idle();
    step(1, 1, 0, 0, 1, 1, 0, 0, 1, 1, "R6");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", "l_busy_out_n", int'(l_bo), 1);
    check("R9", "r_busy_out_n", int'(r_bo), 1);
    check("R9", "l_rdata", int'(l_rdata), 0);
    check("R9", "r_rdata", int'(r_rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 fill every word from the left
    for (int i = 0; i < DEPTH; i++) step(0, 0, i, i ^ 8'hA5, 1, 1, 0, 0, 1, 1, "R1");
    step(0, 1, 5, 0, 0, 1, 6, 0, 1, 1, "R1");
    check("R1", "l read 5", int'(l_rdata), 5 ^ 8'hA5);
    check("R1", "r read 6", int'(r_rdata), 6 ^ 8'hA5);

    // R2 distinct addresses, no busy
    step(0, 0, 30, 8'h30, 0, 0, 31, 8'h31, 1, 1, "R2");
    check("R2", "busy pair", int'({l_bo, r_bo}), 3);

    // R4 tie on the same edge
    step(0, 0, 3, 8'h11, 0, 0, 3, 8'h22, 1, 1, "R4");
    check("R4", "r_busy_out_n", int'(r_bo), 0);
    check("R4", "l_busy_out_n", int'(l_bo), 1);
    idle();
    check("R6", "r_busy_out_n release", int'(r_bo), 1);
    step(1, 1, 0, 0, 0, 1, 3, 0, 1, 1, "R5");
    check("R5", "word 3", int'(r_rdata), 8'h11);

    // R3 left arrives first, right joins with a write
    step(0, 1, 7, 0, 1, 1, 0, 0, 1, 1, "R3");
    step(0, 1, 7, 0, 0, 0, 7, 8'h5A, 1, 1, "R3");
    check("R3", "r_busy_out_n", int'(r_bo), 0);
    step(0, 1, 7, 0, 0, 0, 7, 8'h5A, 1, 1, "R5");
    step(0, 1, 7, 0, 1, 1, 0, 0, 1, 1, "R6");
    check("R6", "r_busy_out_n after cs release", int'(r_bo), 1);
    check("R5", "word 7 kept", int'(l_rdata), 7 ^ 8'hA5);

    // R7 right writes first, left reads in the same edge as a second write
    step(1, 1, 0, 0, 0, 0, 9, 8'h33, 1, 1, "R7");
    step(0, 1, 9, 0, 0, 0, 9, 8'h44, 1, 1, "R7");
    check("R7", "old word", int'(l_rdata), 8'h33);
    check("R3", "l_busy_out_n", int'(l_bo), 0);
    step(0, 1, 9, 0, 1, 1, 0, 0, 1, 1, "R7");
    check("R7", "new word", int'(l_rdata), 8'h44);
    check("R6", "l_busy_out_n", int'(l_bo), 1);

    // R6 address divergence ends the match
    step(0, 1, 14, 0, 0, 1, 14, 0, 1, 1, "R6");
    check("R6", "r busy while matched", int'(r_bo), 0);
    step(0, 1, 14, 0, 0, 1, 15, 0, 1, 1, "R6");
    check("R6", "r busy after divergence", int'(r_bo), 1);

    // R10 ownership held while both stay
    step(0, 0, 12, 8'h10, 1, 1, 0, 0, 1, 1, "R10");
    step(0, 0, 12, 8'h11, 0, 0, 12, 8'h21, 1, 1, "R10");
    step(0, 0, 12, 8'h12, 0, 0, 12, 8'h22, 1, 1, "R10");
    check("R10", "r_busy_out_n", int'(r_bo), 0);
    step(1, 1, 0, 0, 0, 1, 12, 0, 1, 1, "R10");
    check("R10", "word 12", int'(r_rdata), 8'h12);

    // random contention in master mode
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 10) < 3, $urandom % 2, $urandom % 4, $urandom % 256,
           ($urandom % 10) < 3, $urandom % 2, $urandom % 4, $urandom % 256,
           1, 1, "R3");
    end
    idle();

    // R8 slave mode
    mode = 1'b0;
    step(0, 0, 20, 8'h77, 1, 1, 0, 0, 0, 1, "R8");
    check("R8", "busy pair", int'({l_bo, r_bo}), 3);
    step(0, 1, 20, 0, 0, 1, 20, 0, 1, 1, "R8");
    check("R8", "blocked write", int'(l_rdata), 20 ^ 8'hA5);
    check("R8", "busy pair on match", int'({l_bo, r_bo}), 3);
    step(0, 0, 20, 8'h78, 1, 1, 0, 0, 1, 1, "R8");
    step(0, 1, 20, 0, 1, 1, 0, 0, 0, 0, "R8");
    check("R8", "read under busy_in", int'(l_rdata), 8'h78);

    for (int n = 0; n < 2000; n++) begin
      logic lcs, lwe, rcs, rwe, lbi, rbi;
      int la, ra;
      lcs = ($urandom % 10) < 3; lwe = $urandom % 2; la = $urandom % 4;
      rcs = ($urandom % 10) < 3; rwe = $urandom % 2; ra = $urandom % 4;
      lbi = $urandom % 2; rbi = $urandom % 2;
      if (!lcs && !rcs && !lwe && !rwe && la == ra && lbi && rbi) rwe = 1;
      step(lcs, lwe, la, $urandom % 256, rcs, rwe, ra, $urandom % 256, lbi, rbi, "R8");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule